// File: doc/BRIEF.md
# Indirect CSR Access Command Bridge

This bridge lets a host reach an internal bank of up to 256 control/status registers through two host-visible words, a command word and a data word. For a write, the host first loads the data word, then issues a command that carries the start bit, the direction bit and the target index. For a read, it issues only the command. Once the start bit is set, the bridge carries the request into the internal clock domain and runs one request/acknowledge transfer on the internal register bus. It then carries the acknowledge back to the host domain and drops the busy flag. On a read, the returned word is in the data word by the time busy reads zero.

The host side is a finite state machine with two states. In H_IDLE the bridge accepts writes to the command and data words, and a command write with the start bit set moves it to H_WAIT. In H_WAIT both words are frozen, and the acknowledge event from the internal side returns it to H_IDLE. The internal side has three states. In I_IDLE it waits for a new request toggle, which moves it to I_BUS. In I_BUS it holds the bus request until the acknowledge arrives, which moves it to I_RESP. In I_RESP it flips the acknowledge toggle and returns to I_IDLE. Each direction crosses between the clock domains through its own toggle and a two-flop synchronizer.

Top module: `csr_cmd_bridge`

## Requirements
- R1: After reset, the command word (h_sel=0) and the data word (h_sel=1) both read 0, and i_req is low.
- R2: A host write of the command word with bit 31 = 1 makes bit 31 of the command word (busy) read 1 at the next host clock. Busy stays 1 for as long as the internal transfer is in progress, which includes every cycle in which i_req is high.
- R3: Command word readback places the direction in bit 30 (1 = read, 0 = write) and the register index in bits 7:0. Bits 29:8 always read 0.
- R4: A write command produces a single bus transfer with i_we=1, i_addr equal to the index, and i_wdata equal to the data word. These stay stable until i_ack.
- R5: A read command produces a bus transfer with i_we=0. When busy returns to 0, the data word holds the i_rdata that the bus returned.
- R6: While busy is 1, host writes to either word are ignored. Neither word changes, and no extra transfer starts.
- R7: A command write with bit 31 = 0 updates the direction and index fields only. It starts no transfer, and busy stays 0.
- R8: i_req stays high until i_ack is sampled and drops in the next internal clock cycle. Each started command produces exactly one transfer.
- R9: After a write command completes, the data word still holds the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Host clock |
| rst_h_n | input | 1 | Host-domain reset, active low |
| h_wen | input | 1 | Host write strobe |
| h_sel | input | 1 | Word select: 0 = command, 1 = data |
| h_wdata | input | 32 | Host write value |
| h_rdata | output | 32 | Readback of the selected word |
| clk_i | input | 1 | Internal register bus clock |
| rst_i_n | input | 1 | Internal-domain reset, active low |
| i_req | output | 1 | Bus request, held until acknowledged |
| i_we | output | 1 | Bus direction, 1 = write |
| i_addr | output | 8 | Target register index |
| i_wdata | output | 32 | Bus write value |
| i_ack | input | 1 | Single-cycle bus acknowledge |
| i_rdata | input | 32 | Bus read value, valid with i_ack |

## Verification
A table of mixed writes and reads is applied with the index set to zero, the top value 0xFF, mid values, and indices that have never been written. Read results are therefore compared against three distinct sources: values just stored by the bench, stored values that were later overwritten with zero, and the responder's initial pattern. This separates index errors from direction errors and from errors in capturing the returned data. Directed tests then issue writes to both words during a transfer, and a command with the start bit clear carrying ones in the reserved bits. These show whether the freeze holds, whether a second transfer is launched, and how the fields are masked. The two clocks run at different rates, so a bridge that dropped busy before the acknowledge crossed back would fail the read-data comparison.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
    localparam int CSR_DATA_W = 32;
    localparam int CSR_ADDR_W = 8;
    localparam int CSR_SYNC_N = 2;

    typedef enum logic [0:0] {
        H_IDLE,
        H_WAIT
    } host_st_e;

    typedef enum logic [1:0] {
        I_IDLE,
        I_BUS,
        I_RESP
    } int_st_e;
endpackage

// File: rtl/csr_bit_sync.sv
module csr_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/csr_host_ctl.sv
module csr_host_ctl
    import csr_bridge_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    input  logic          ack_tgl_s,
    input  logic [DW-1:0] ret_data,
    output logic          busy,
    output logic          ack_evt,
    output logic          req_tgl,
    output logic          cmd_dir,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] data_q
);
    localparam int START_B = DW - 1;
    localparam int DIR_B   = DW - 2;

    host_st_e state, state_nx;
    logic     ack_seen;

    assign ack_evt = ack_tgl_s ^ ack_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= H_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            H_IDLE: if (wr_cmd && wdata[START_B]) state_nx = H_WAIT;
            H_WAIT: if (ack_evt)                  state_nx = H_IDLE;
            default:                              state_nx = H_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_seen <= 1'b0;
            req_tgl  <= 1'b0;
            cmd_dir  <= 1'b0;
            cmd_addr <= '0;
            data_q   <= '0;
        end else begin
            ack_seen <= ack_tgl_s;
            unique case (state)
                H_IDLE: begin
                    if (wr_cmd) begin
                        cmd_dir  <= wdata[DIR_B];
                        cmd_addr <= wdata[AW-1:0];
                        if (wdata[START_B]) req_tgl <= ~req_tgl;
                    end
                    if (wr_data) data_q <= wdata;
                end
                H_WAIT: begin
                    if (ack_evt && cmd_dir) data_q <= ret_data;
                end
                default: ;
            endcase
        end
    end

    always_comb busy = (state == H_WAIT);
endmodule

// File: rtl/csr_int_ctl.sv
module csr_int_ctl
    import csr_bridge_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_tgl_s,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          ack_tgl,
    output logic [DW-1:0] ret_data
);
    int_st_e state, state_nx;
    logic    req_seen;
    logic    new_req;

    assign new_req = req_tgl_s ^ req_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= I_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            I_IDLE:  if (new_req) state_nx = I_BUS;
            I_BUS:   if (bus_ack) state_nx = I_RESP;
            I_RESP:               state_nx = I_IDLE;
            default:              state_nx = I_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
            ret_data <= '0;
        end else begin
            unique case (state)
                I_IDLE:  if (new_req) req_seen <= req_tgl_s;
                I_BUS:   if (bus_ack) ret_data <= bus_rdata;
                I_RESP:  ack_tgl <= ~ack_tgl;
                default: ;
            endcase
        end
    end

    always_comb bus_req = (state == I_BUS);
endmodule

// File: rtl/csr_cmd_bridge.sv
module csr_cmd_bridge
    import csr_bridge_pkg::*;
#(
    parameter int DATA_W      = CSR_DATA_W,
    parameter int ADDR_W      = CSR_ADDR_W,
    parameter int SYNC_STAGES = CSR_SYNC_N
) (
    input  logic              clk_h,
    input  logic              rst_h_n,
    input  logic              h_wen,
    input  logic              h_sel,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              clk_i,
    input  logic              rst_i_n,
    output logic              i_req,
    output logic              i_we,
    output logic [ADDR_W-1:0] i_addr,
    output logic [DATA_W-1:0] i_wdata,
    input  logic              i_ack,
    input  logic [DATA_W-1:0] i_rdata
);
    localparam int RSV_W = DATA_W - 2 - ADDR_W;

    logic              busy, ack_evt, req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
    logic              cmd_dir;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] data_q, ret_data;
    logic [DATA_W-1:0] cmd_word;

    csr_host_ctl #(.DW(DATA_W), .AW(ADDR_W)) u_host (
        .clk       (clk_h),
        .rst_n     (rst_h_n),
        .wr_cmd    (h_wen && !h_sel),
        .wr_data   (h_wen && h_sel),
        .wdata     (h_wdata),
        .ack_tgl_s (ack_tgl_s),
        .ret_data  (ret_data),
        .busy      (busy),
        .ack_evt   (ack_evt),
        .req_tgl   (req_tgl),
        .cmd_dir   (cmd_dir),
        .cmd_addr  (cmd_addr),
        .data_q    (data_q)
    );

    csr_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk_i), .rst_n(rst_i_n), .d(req_tgl), .q(req_tgl_s)
    );

    csr_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk_h), .rst_n(rst_h_n), .d(ack_tgl), .q(ack_tgl_s)
    );

    csr_int_ctl #(.DW(DATA_W)) u_int (
        .clk       (clk_i),
        .rst_n     (rst_i_n),
        .req_tgl_s (req_tgl_s),
        .bus_ack   (i_ack),
        .bus_rdata (i_rdata),
        .bus_req   (i_req),
        .ack_tgl   (ack_tgl),
        .ret_data  (ret_data)
    );

    assign cmd_word = {busy, cmd_dir, {RSV_W{1'b0}}, cmd_addr};
    assign h_rdata  = h_sel ? data_q : cmd_word;
    assign i_we     = ~cmd_dir;
    assign i_addr   = cmd_addr;
    assign i_wdata  = data_q;
endmodule

// File: rtl/csr_bridge_chk.sv
module csr_bridge_chk #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk_h,
    input logic          rst_h_n,
    input logic          clk_i,
    input logic          rst_i_n,
    input logic          h_wen,
    input logic          h_sel,
    input logic          start_bit,
    input logic          busy,
    input logic          ack_evt,
    input logic          i_req,
    input logic          i_ack,
    input logic          i_we,
    input logic [AW-1:0] i_addr,
    input logic [DW-1:0] i_wdata
);
    logic launch;
    assign launch = h_wen && !h_sel && start_bit;

    a_r2_start_sets_busy: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        (launch && !busy) |=> busy);

    a_r2_busy_until_ack: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        (busy && !ack_evt) |=> busy);

    a_r6_fields_frozen: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        (busy && !ack_evt) |=> ($stable(i_addr) && $stable(i_we) && $stable(i_wdata)));

    a_r7_idle_without_start: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        (!busy && !launch) |=> !busy);

    a_r4_req_payload_hold: assert property (@(posedge clk_i) disable iff (!rst_i_n)
        (i_req && !i_ack) |=> (i_req && $stable(i_addr) && $stable(i_we) && $stable(i_wdata)));

    a_r8_req_drops: assert property (@(posedge clk_i) disable iff (!rst_i_n)
        (i_req && i_ack) |=> !i_req);
endmodule

bind csr_cmd_bridge csr_bridge_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
    .clk_h     (clk_h),
    .rst_h_n   (rst_h_n),
    .clk_i     (clk_i),
    .rst_i_n   (rst_i_n),
    .h_wen     (h_wen),
    .h_sel     (h_sel),
    .start_bit (h_wdata[DATA_W-1]),
    .busy      (busy),
    .ack_evt   (ack_evt),
    .i_req     (i_req),
    .i_ack     (i_ack),
    .i_we      (i_we),
    .i_addr    (i_addr),
    .i_wdata   (i_wdata)
);

// File: tb/csr_cmd_bridge_tb.sv
`timescale 1ns/1ps
module csr_cmd_bridge_tb;
    logic        clk_h = 1'b0, clk_i = 1'b0;
    logic        rst_h_n = 1'b0, rst_i_n = 1'b0;
    logic        h_wen = 1'b0, h_sel = 1'b0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        i_req, i_we, i_ack;
    logic [7:0]  i_addr;
    logic [31:0] i_wdata, i_rdata;

    int errors = 0, checks = 0;
    int acks = 0, starts = 0, dly = 0;
    logic        prev_req;
    logic [31:0] mem [256];

    always #2   clk_h = ~clk_h;
    always #3.5 clk_i = ~clk_i;

    csr_cmd_bridge u_dut (
        .clk_h(clk_h), .rst_h_n(rst_h_n), .h_wen(h_wen), .h_sel(h_sel),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .clk_i(clk_i), .rst_i_n(rst_i_n),
        .i_req(i_req), .i_we(i_we), .i_addr(i_addr), .i_wdata(i_wdata),
        .i_ack(i_ack), .i_rdata(i_rdata)
    );

    // register bank responder: acknowledges after three cycles of request
    always @(posedge clk_i) begin
        if (!rst_i_n) begin
            i_ack <= 1'b0; i_rdata <= '0; dly <= 0; acks <= 0;
            starts <= 0; prev_req <= 1'b0;
            for (int k = 0; k < 256; k++) mem[k] <= 32'h5A00_0000 | 32'(k);
        end else begin
            prev_req <= i_req;
            if (i_req && !prev_req) starts <= starts + 1;
            i_ack <= 1'b0;
            if (i_req && !i_ack) begin
                if (dly == 2) begin
                    dly   <= 0;
                    i_ack <= 1'b1;
                    acks  <= acks + 1;
                    if (i_we) mem[i_addr] <= i_wdata;
                    else      i_rdata     <= mem[i_addr];
                end else begin
                    dly <= dly + 1;
                end
            end
        end
    end

    typedef struct packed {
        logic        rd;
        logic [7:0]  idx;
        logic [31:0] val;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'hA5A5_0F0F},
        '{1'b0, 8'hFF, 32'h1234_5678},
        '{1'b1, 8'h10, 32'h5A00_0010},
        '{1'b0, 8'h7F, 32'hDEAD_BEEF},
        '{1'b1, 8'h00, 32'hA5A5_0F0F},
        '{1'b1, 8'hFF, 32'h1234_5678},
        '{1'b1, 8'h7F, 32'hDEAD_BEEF},
        '{1'b0, 8'h00, 32'h0000_0000},
        '{1'b1, 8'h00, 32'h0000_0000},
        '{1'b1, 8'h80, 32'h5A00_0080}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a host negedge, returns at the next host negedge
    task automatic hw(input logic sel, input logic [31:0] v);
        h_sel = sel; h_wdata = v; h_wen = 1'b1;
        @(negedge clk_h);
        h_wen = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        h_sel = sel; #0.1; v = h_rdata;
    endtask

    task automatic wait_idle(output int bad);
        logic [31:0] w;
        bad = 0;
        for (int n = 0; n < 400; n++) begin
            rd(1'b0, w);
            if (i_req && !w[31]) bad++;
            if (!w[31]) return;
            @(negedge clk_h);
        end
        bad = 1000;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] w;
        int bad, a0, s0;
        repeat (10) @(negedge clk_h);
        rst_h_n = 1'b1; rst_i_n = 1'b1;
        @(negedge clk_h);

        // R1 reset state
        rd(1'b0, w); chk("R1 command word", w, 32'h0);
        rd(1'b1, w); chk("R1 data word", w, 32'h0);
        chk("R1 i_req", {31'b0, i_req}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            a0 = acks; s0 = starts;
            if (!VECS[v].rd) hw(1'b1, VECS[v].val);
            hw(1'b0, {1'b1, VECS[v].rd, 22'h3FFFFF, VECS[v].idx});
            rd(1'b0, w);
            chk("R2 busy after start", {31'b0, w[31]}, 32'h1);
            chk("R3 command fields", {1'b0, w[30:0]}, {1'b0, VECS[v].rd, 22'h0, VECS[v].idx});
            wait_idle(bad);
            chk("R2 busy held during transfer", 32'(bad), 32'h0);
            repeat (8) @(negedge clk_h);
            chk("R8 one transfer per command", 32'(starts - s0), 32'h1);
            chk("R8 one acknowledge per command", 32'(acks - a0), 32'h1);
            rd(1'b1, w);
            if (VECS[v].rd) begin
                chk("R5 read data returned", w, VECS[v].val);
            end else begin
                chk("R9 data word kept", w, VECS[v].val);
                chk("R4 value stored at index", mem[VECS[v].idx], VECS[v].val);
            end
        end

        // R6 writes while busy are ignored
        a0 = acks; s0 = starts;
        hw(1'b0, 32'hC000_0010);
        hw(1'b1, 32'hFFFF_FFFF);
        hw(1'b0, 32'h8000_0044);
        rd(1'b1, w); chk("R6 data frozen while busy", w, 32'h5A00_0080);
        rd(1'b0, w); chk("R6 command frozen while busy", w, 32'hC000_0010);
        wait_idle(bad);
        chk("R6 transfer completed", 32'(bad), 32'h0);
        repeat (12) @(negedge clk_h);
        rd(1'b1, w); chk("R6 read result after ignored writes", w, 32'h5A00_0010);
        rd(1'b0, w); chk("R6 command after ignored write", w, 32'h4000_0010);
        chk("R6 no extra transfer", 32'(starts - s0), 32'h1);

        // R7 command write with start clear; R3 reserved bits masked
        s0 = starts;
        hw(1'b0, 32'h7FFF_FF33);
        rd(1'b0, w); chk("R7 fields updated, not busy", w, 32'h4000_0033);
        repeat (40) @(negedge clk_h);
        rd(1'b0, w); chk("R7 still idle", w, 32'h4000_0033);
        chk("R7 no transfer started", 32'(starts - s0), 32'h0);
        chk("R7 no request on bus", {31'b0, i_req}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule